// File: doc/BRIEF.md
# Load/Store Address Router

This block sits between the load/store port of a 32-bit processor and the targets behind it. Each request gives an address, an access size, a write flag and write data. The block decodes the address into one of seven regions. These are an internal SRAM at the bottom of the address space, a 1 MB external RAM window, a UART transmit register, an interrupt mask register, an interrupt status register, a small TLB register window, or nothing at all. The block then drives the select and strobe signals of that single target. For RAM, the data is moved onto byte lanes for big-endian or little-endian order. Memory words are stored in address order: lane k, bits [8k+7:8k], holds the byte at word offset k. For a misaligned access the block drives no strobe and reports a fault.

The interrupt mask and status registers are held inside the block and are visible on output ports. Status bit 0 is the transmit-free flag. Bit 1 is the MMU-pending flag. The block takes one request at a time. It uses a three-state machine:

- **S_IDLE** accepts a request.
  - Transition *start RAM read*: an aligned read of SRAM or external RAM moves to **S_RAM_READ**.
  - Transition *finish now*: any other request moves to **S_REPLY**.
- **S_RAM_READ** latches the returned RAM word and steers it onto the correct lanes. Transition *data back* moves to **S_REPLY**.
- **S_REPLY** presents the response for one cycle. Transition *done* moves back to **S_IDLE**.

Top module: `bus_router`

## Requirements
- R1: A write to address 0x20000000 pulses `uart_tx_valid` for one cycle and places `req_wdata[7:0]` on `uart_tx_byte`. It selects no RAM, and it clears status bit 0 (transmit-free).
- R2: Addresses from 0x10000000 up to, but not including, 0x10100000 assert `ext_sel`, with `mem_addr` equal to the address minus 0x10000000. Address 0x10100000 is unmapped.
- R3: Addresses below 0x2000 assert `sram_sel`, with `mem_addr` equal to the address. Address 0x2000 is unmapped.
- R4: A write to the TLB window, eight words starting at 0x20000100, does three things:
  - it pulses `tlb_we`;
  - it drives `tlb_index` with (address − 0x20000100)/4 and `tlb_wdata` with the write data;
  - it clears status bit 1.
  A pulse on `mmu_fault_set` sets status bit 1. If both happen in the same cycle, the set wins. A write at 0x20000120 is outside the window.
- R5: A write to 0x20000010 stores all 32 bits in `irq_mask`, visible from the next cycle. A read of that address returns the stored value.
- R6: Alignment rules are:
  - a word access (size code 2) needs address bits [1:0] equal to 0;
  - a halfword access (size code 1) needs bit 0 equal to 0;
  - size code 3 is always faulted.
  A faulted access drives no select, no `mem_we`, no `mem_be` and no other strobe. Its response has `rsp_fault`=1 and `rsp_rdata`=0, and it leaves the status register unchanged.
- R7: With `big_endian`=1, the byte order of word and halfword data is swapped:
  - a word read returns {lane0, lane1, lane2, lane3};
  - a halfword at offset h returns {lane h, lane h+1};
  - a written halfword puts `wdata[15:8]` on lane h.
- R8: With `big_endian`=0, data follows the lanes directly:
  - a word passes unchanged;
  - a halfword at offset h returns {lane h+1, lane h}.
- R9: Byte enables and write data are:
  - byte access (size 0): `mem_be` = 1 << addr[1:0] in either mode, with the byte repeated on every lane;
  - halfword: `mem_be` = 4'b0011 at offset 0 and 4'b1100 at offset 2;
  - word: 4'b1111.
  Byte and halfword reads return zero-extended values.
- R10: Every accepted aligned read sets status bit 0 from the next cycle. A read of the status register (0x20000020) returns the value from before its own effect.
- R11: Unmapped accesses have these results:
  - an unmapped read, or a read of the UART or TLB addresses, returns 0 with no fault, in one response cycle;
  - an unmapped write drives no strobe.
- R12: `req_ready` is high only in S_IDLE. The response (`rsp_valid`) is a one-cycle pulse. It comes two cycles after acceptance for RAM reads and one cycle after acceptance for everything else.
- R13: After reset the block is in S_IDLE, with `req_ready`=1, `rsp_valid`=0, `irq_mask`=0 and `irq_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Selects big-endian lane steering for the request being accepted |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | Request accepted this cycle if valid (S_IDLE) |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write value, right-justified |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read value, zero outside the response |
| rsp_fault | output | 1 | Alignment fault flag for this response |
| mem_addr | output | 20 | Byte offset into the selected RAM |
| mem_be | output | 4 | RAM byte-lane enables |
| mem_wdata | output | 32 | RAM write data on lanes |
| mem_we | output | 1 | RAM write strobe |
| sram_sel | output | 1 | Internal SRAM select |
| sram_rdata | input | 32 | SRAM word, valid the cycle after select |
| ext_sel | output | 1 | External RAM select |
| ext_rdata | input | 32 | External RAM word, valid the cycle after select |
| uart_tx_valid | output | 1 | UART transmit strobe |
| uart_tx_byte | output | 8 | Byte to transmit |
| tlb_we | output | 1 | TLB word write strobe |
| tlb_index | output | 3 | Word index inside the TLB window |
| tlb_wdata | output | 32 | TLB word value |
| mmu_fault_set | input | 1 | Sets the MMU-pending status bit |
| irq_mask | output | 32 | Interrupt mask register |
| irq_status | output | 32 | Interrupt status register (bit 0 transmit-free, bit 1 MMU-pending) |

## Verification
The in-line properties check the following on every cycle:
- at most one target is strobed;
- a faulted access strobes nothing;
- a byte write enables exactly one lane;
- the response is a single-cycle pulse that never overlaps readiness;
- a RAM read always replies on the cycle after its data phase;
- the status bits react to reads, TLB writes and MMU events;
- the mask holds its value when not written.

Some behaviour can only be shown by the bench's scenarios: the exact region boundaries at 0x2000 and 0x10100000, the lane placement and byte swapping in each mode and for each size and offset, the read-back of the mask and status registers, and the set-over-clear priority of the MMU-pending bit.

// File: rtl/bus_map_pkg.sv
package bus_map_pkg;

    localparam int WORD_W = 32;

    localparam logic [31:0] UART_TX_ADDR  = 32'h2000_0000;
    localparam logic [31:0] IRQ_MASK_ADDR = 32'h2000_0010;
    localparam logic [31:0] IRQ_STAT_ADDR = 32'h2000_0020;
    localparam logic [31:0] TLB_BASE_ADDR = 32'h2000_0100;
    localparam logic [31:0] EXT_BASE_ADDR = 32'h1000_0000;

    localparam int STAT_TX_FREE  = 0;
    localparam int STAT_MMU_PEND = 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SRAM,
        RG_EXT,
        RG_UART,
        RG_MASK,
        RG_STAT,
        RG_TLB
    } region_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RAM_READ,
        S_REPLY
    } rtr_state_e;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/bus_addr_decode.sv
module bus_addr_decode
    import bus_map_pkg::*;
#(
    parameter int SRAM_BYTES  = 8192,
    parameter int EXT_BYTES   = 1 << 20,
    parameter int TLB_ENTRIES = 4,
    localparam int OFF_W      = $clog2(EXT_BYTES),
    localparam int TLB_WORDS  = 2 * TLB_ENTRIES,
    localparam int TIDX_W     = $clog2(TLB_WORDS)
) (
    input  logic [WORD_W-1:0] addr,
    input  acc_size_e         size,
    output region_e           region,
    output logic [OFF_W-1:0]  offset,
    output logic [TIDX_W-1:0] tlb_idx,
    output logic              misalign
);

    localparam logic [31:0] TLB_SPAN = 32'(4 * TLB_WORDS);
    localparam logic [31:0] EXT_SPAN = 32'(EXT_BYTES);
    localparam logic [31:0] SRAM_TOP = 32'(SRAM_BYTES);

    logic [31:0] ext_rel;
    logic [31:0] tlb_rel;

    always_comb begin
        ext_rel = addr - EXT_BASE_ADDR;
        tlb_rel = addr - TLB_BASE_ADDR;

        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = addr[0];
            SZ_WORD: misalign = |addr[1:0];
            default: misalign = 1'b1;
        endcase

        region = RG_NONE;
        offset = '0;
        if (addr == UART_TX_ADDR) begin
            region = RG_UART;
        end else if (addr == IRQ_MASK_ADDR) begin
            region = RG_MASK;
        end else if (addr == IRQ_STAT_ADDR) begin
            region = RG_STAT;
        end else if (addr >= TLB_BASE_ADDR && tlb_rel < TLB_SPAN) begin
            region = RG_TLB;
        end else if (addr >= EXT_BASE_ADDR && ext_rel < EXT_SPAN) begin
            region = RG_EXT;
            offset = ext_rel[OFF_W-1:0];
        end else if (addr < SRAM_TOP) begin
            region = RG_SRAM;
            offset = addr[OFF_W-1:0];
        end

        tlb_idx = tlb_rel[TIDX_W+1:2];
    end

endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
    import bus_map_pkg::*;
(
    input  logic              w_big,
    input  acc_size_e         w_size,
    input  logic [1:0]        w_offs,
    input  logic [WORD_W-1:0] w_data,
    output logic [3:0]        w_be,
    output logic [WORD_W-1:0] w_lanes,
    input  logic              r_big,
    input  acc_size_e         r_size,
    input  logic [1:0]        r_offs,
    input  logic [WORD_W-1:0] r_word,
    output logic [WORD_W-1:0] r_value
);

    localparam int LANES = WORD_W / 8;

    logic [15:0]        w_pair;
    logic [WORD_W-1:0]  r_shift;
    logic [15:0]        r_half;
    logic [LANES-1:0]   byte_sel;

    // one-hot lane pick for byte access, one bit per lane
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign byte_sel[k] = (w_offs == 2'(k));
    end

    always_comb begin
        w_pair = w_big ? {w_data[7:0], w_data[15:8]} : w_data[15:0];
        unique case (w_size)
            SZ_BYTE: begin
                w_be    = byte_sel;
                w_lanes = {LANES{w_data[7:0]}};
            end
            SZ_HALF: begin
                w_be    = w_offs[1] ? 4'b1100 : 4'b0011;
                w_lanes = {2{w_pair}};
            end
            default: begin
                w_be    = 4'b1111;
                w_lanes = w_big ? swap_bytes(w_data) : w_data;
            end
        endcase
    end

    always_comb begin
        r_shift = r_word >> {r_offs, 3'b000};
        r_half  = r_shift[15:0];
        unique case (r_size)
            SZ_BYTE: r_value = {24'b0, r_shift[7:0]};
            SZ_HALF: r_value = {16'b0, (r_big ? {r_half[7:0], r_half[15:8]} : r_half)};
            default: r_value = r_big ? swap_bytes(r_word) : r_word;
        endcase
    end

endmodule

// File: rtl/bus_irq_regs.sv
module bus_irq_regs
    import bus_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [WORD_W-1:0] mask_wdata,
    input  logic              read_evt,
    input  logic              txfree_clr,
    input  logic              tlb_evt,
    input  logic              mmu_set,
    output logic [WORD_W-1:0] mask_q,
    output logic [WORD_W-1:0] status_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            if (read_evt) begin
                status_q[STAT_TX_FREE] <= 1'b1;
            end else if (txfree_clr) begin
                status_q[STAT_TX_FREE] <= 1'b0;
            end
            if (mmu_set) begin
                status_q[STAT_MMU_PEND] <= 1'b1;
            end else if (tlb_evt) begin
                status_q[STAT_MMU_PEND] <= 1'b0;
            end
        end
    end

    p_read_sets_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        read_evt |=> status_q[STAT_TX_FREE]);

    p_uart_clears_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (txfree_clr && !read_evt) |=> !status_q[STAT_TX_FREE]);

    p_tlb_clears_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_evt && !mmu_set) |=> !status_q[STAT_MMU_PEND]);

    p_mmu_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_set |=> status_q[STAT_MMU_PEND]);

    p_mask_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));

endmodule

// File: rtl/bus_router.sv
module bus_router
    import bus_map_pkg::*;
#(
    parameter int SRAM_BYTES  = 8192,
    parameter int EXT_BYTES   = 1 << 20,
    parameter int TLB_ENTRIES = 4,
    localparam int OFF_W      = $clog2(EXT_BYTES),
    localparam int TIDX_W     = $clog2(2 * TLB_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_fault,
    output logic [OFF_W-1:0]  mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              mem_we,
    output logic              sram_sel,
    input  logic [31:0]       sram_rdata,
    output logic              ext_sel,
    input  logic [31:0]       ext_rdata,
    output logic              uart_tx_valid,
    output logic [7:0]        uart_tx_byte,
    output logic              tlb_we,
    output logic [TIDX_W-1:0] tlb_index,
    output logic [31:0]       tlb_wdata,
    input  logic              mmu_fault_set,
    output logic [31:0]       irq_mask,
    output logic [31:0]       irq_status
);

    rtr_state_e        state, state_nx;
    acc_size_e         sz;
    region_e           region;
    logic [OFF_W-1:0]  offset;
    logic [TIDX_W-1:0] tidx;
    logic              misalign;
    logic              accept, ok, is_ram;
    logic              mask_we_w, read_evt_w, uart_evt_w, tlb_evt_w;
    logic [3:0]        be_w;
    logic [31:0]       lanes_w;
    logic [31:0]       reg_rdata;

    logic              lat_big, lat_ext;
    acc_size_e         lat_size;
    logic [1:0]        lat_offs;
    logic [31:0]       rsp_data_q;
    logic              rsp_fault_q;
    logic [31:0]       ram_word, ram_value;

    assign sz = acc_size_e'(req_size);

    bus_addr_decode #(
        .SRAM_BYTES (SRAM_BYTES),
        .EXT_BYTES  (EXT_BYTES),
        .TLB_ENTRIES(TLB_ENTRIES)
    ) u_decode (
        .addr    (req_addr),
        .size    (sz),
        .region  (region),
        .offset  (offset),
        .tlb_idx (tidx),
        .misalign(misalign)
    );

    assign ram_word = lat_ext ? ext_rdata : sram_rdata;

    bus_lane_steer u_steer (
        .w_big  (big_endian),
        .w_size (sz),
        .w_offs (req_addr[1:0]),
        .w_data (req_wdata),
        .w_be   (be_w),
        .w_lanes(lanes_w),
        .r_big  (lat_big),
        .r_size (lat_size),
        .r_offs (lat_offs),
        .r_word (ram_word),
        .r_value(ram_value)
    );

    bus_irq_regs u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we_w),
        .mask_wdata(req_wdata),
        .read_evt  (read_evt_w),
        .txfree_clr(uart_evt_w),
        .tlb_evt   (tlb_evt_w),
        .mmu_set   (mmu_fault_set),
        .mask_q    (irq_mask),
        .status_q  (irq_status)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (!misalign && !req_write && is_ram) begin
                        state_nx = S_RAM_READ;
                    end else begin
                        state_nx = S_REPLY;
                    end
                end
            end
            S_RAM_READ: state_nx = S_REPLY;
            S_REPLY:    state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            S_IDLE:     req_ready = 1'b1;
            S_RAM_READ: req_ready = 1'b0;
            S_REPLY:    rsp_valid = 1'b1;
            default:    req_ready = 1'b0;
        endcase

        accept = req_valid && req_ready;
        ok     = accept && !misalign;
        is_ram = (region == RG_SRAM) || (region == RG_EXT);

        sram_sel      = ok && (region == RG_SRAM);
        ext_sel       = ok && (region == RG_EXT);
        mem_we        = ok && is_ram && req_write;
        mem_be        = (ok && is_ram) ? be_w : 4'b0000;
        mem_wdata     = (ok && is_ram) ? lanes_w : '0;
        mem_addr      = offset;

        uart_evt_w    = ok && req_write && (region == RG_UART);
        tlb_evt_w     = ok && req_write && (region == RG_TLB);
        mask_we_w     = ok && req_write && (region == RG_MASK);
        read_evt_w    = ok && !req_write;

        uart_tx_valid = uart_evt_w;
        uart_tx_byte  = req_wdata[7:0];
        tlb_we        = tlb_evt_w;
        tlb_index     = tidx;
        tlb_wdata     = req_wdata;

        rsp_rdata     = rsp_valid ? rsp_data_q : '0;
        rsp_fault     = rsp_valid && rsp_fault_q;
    end

    always_comb begin
        unique case (region)
            RG_MASK: reg_rdata = irq_mask;
            RG_STAT: reg_rdata = irq_status;
            default: reg_rdata = '0;
        endcase
    end

    // request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_big     <= 1'b0;
            lat_ext     <= 1'b0;
            lat_size    <= SZ_WORD;
            lat_offs    <= 2'b00;
            rsp_data_q  <= '0;
            rsp_fault_q <= 1'b0;
        end else if (accept) begin
            lat_big     <= big_endian;
            lat_ext     <= (region == RG_EXT);
            lat_size    <= sz;
            lat_offs    <= req_addr[1:0];
            rsp_fault_q <= misalign;
            rsp_data_q  <= misalign ? '0 : reg_rdata;
        end else if (state == S_RAM_READ) begin
            rsp_data_q  <= ram_value;
        end
    end

    p_single_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_sel, ext_sel, uart_tx_valid, tlb_we, mask_we_w}));

    p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && misalign) |-> !(sram_sel || ext_sel || mem_we || uart_tx_valid || tlb_we || mask_we_w));

    p_byte_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && sz == SZ_BYTE) |-> ($countones(mem_be) == 1));

    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ram_reply_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RAM_READ) |=> rsp_valid);

    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

// File: tb/test_bus_router.sv
module test_bus_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_fault;
    logic [19:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        sram_sel;
    logic [31:0] sram_rdata = 32'h1122_3344;
    logic        ext_sel;
    logic [31:0] ext_rdata = 32'hA1B2_C3D4;
    logic        uart_tx_valid;
    logic [7:0]  uart_tx_byte;
    logic        tlb_we;
    logic [2:0]  tlb_index;
    logic [31:0] tlb_wdata;
    logic        mmu_fault_set = 1'b0;
    logic [31:0] irq_mask;
    logic [31:0] irq_status;

    always #2 clk = ~clk;

    bus_router i_bus_router (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .sram_sel(sram_sel), .sram_rdata(sram_rdata),
        .ext_sel(ext_sel), .ext_rdata(ext_rdata),
        .uart_tx_valid(uart_tx_valid), .uart_tx_byte(uart_tx_byte),
        .tlb_we(tlb_we), .tlb_index(tlb_index), .tlb_wdata(tlb_wdata),
        .mmu_fault_set(mmu_fault_set), .irq_mask(irq_mask), .irq_status(irq_status)
    );

    int  checks = 0;
    int  errs   = 0;
    bit  done   = 1'b0;

    // values captured by the access task
    logic        c_sram, c_ext, c_we, c_uart, c_tlb, c_busy, c_fault;
    logic [3:0]  c_be;
    logic [31:0] c_wd, c_rdata, c_tdata;
    logic [19:0] c_maddr;
    logic [7:0]  c_ubyte;
    logic [2:0]  c_tidx;
    int          c_lat;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] addr, input logic [1:0] size, input logic wr,
                          input logic [31:0] wdata, input logic big, input logic mmu);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = size; req_write = wr;
        req_wdata = wdata; big_endian = big; mmu_fault_set = mmu;
        #1;
        c_sram = sram_sel; c_ext = ext_sel; c_we = mem_we; c_be = mem_be;
        c_wd = mem_wdata; c_maddr = mem_addr; c_uart = uart_tx_valid;
        c_ubyte = uart_tx_byte; c_tlb = tlb_we; c_tidx = tlb_index; c_tdata = tlb_wdata;
        @(negedge clk);
        req_valid = 1'b0; mmu_fault_set = 1'b0;
        c_busy = req_ready;
        c_lat = 1;
        while (!rsp_valid && c_lat < 5) begin
            @(negedge clk);
            c_lat++;
        end
        c_rdata = rsp_rdata; c_fault = rsp_fault;
    endtask

    typedef struct packed {
        logic [7:0]  tag;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic        big;
        logic [31:0] wdata;
        logic [1:0]  sel;    // {ext, sram}
        logic [3:0]  be;
        logic [31:0] wd;
        logic [19:0] maddr;
        logic [31:0] rdata;
        logic        fault;
        logic [2:0]  lat;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  32'h0000_0100, 2'd2, 1'b0, 1'b0, 32'h0,         2'b01, 4'hf, 32'h0,         20'h00100, 32'h1122_3344, 1'b0, 3'd2}, // R3 R8
        '{8'd7,  32'h0000_0104, 2'd2, 1'b0, 1'b1, 32'h0,         2'b01, 4'hf, 32'h0,         20'h00104, 32'h4433_2211, 1'b0, 3'd2}, // R7
        '{8'd8,  32'h1000_0002, 2'd1, 1'b0, 1'b0, 32'h0,         2'b10, 4'hc, 32'h0,         20'h00002, 32'h0000_A1B2, 1'b0, 3'd2}, // R8
        '{8'd7,  32'h1000_0006, 2'd1, 1'b0, 1'b1, 32'h0,         2'b10, 4'hc, 32'h0,         20'h00006, 32'h0000_B2A1, 1'b0, 3'd2}, // R7
        '{8'd7,  32'h1000_0000, 2'd1, 1'b0, 1'b1, 32'h0,         2'b10, 4'h3, 32'h0,         20'h00000, 32'h0000_D4C3, 1'b0, 3'd2}, // R7
        '{8'd2,  32'h100F_FFFF, 2'd0, 1'b0, 1'b1, 32'h0,         2'b10, 4'h8, 32'h0,         20'hFFFFF, 32'h0000_00A1, 1'b0, 3'd2}, // R2
        '{8'd9,  32'h0000_1FFD, 2'd0, 1'b1, 1'b0, 32'h0000_00AB, 2'b01, 4'h2, 32'hABAB_ABAB, 20'h01FFD, 32'h0,         1'b0, 3'd1}, // R9
        '{8'd9,  32'h1000_0010, 2'd1, 1'b1, 1'b1, 32'h0000_BEEF, 2'b10, 4'h3, 32'hEFBE_EFBE, 20'h00010, 32'h0,         1'b0, 3'd1}, // R9 R7
        '{8'd8,  32'h1000_0012, 2'd1, 1'b1, 1'b0, 32'h0000_BEEF, 2'b10, 4'hc, 32'hBEEF_BEEF, 20'h00012, 32'h0,         1'b0, 3'd1}, // R8 R9
        '{8'd7,  32'h0000_0008, 2'd2, 1'b1, 1'b1, 32'h0102_0304, 2'b01, 4'hf, 32'h0403_0201, 20'h00008, 32'h0,         1'b0, 3'd1}, // R7
        '{8'd8,  32'h0000_000C, 2'd2, 1'b1, 1'b0, 32'h0102_0304, 2'b01, 4'hf, 32'h0102_0304, 20'h0000C, 32'h0,         1'b0, 3'd1}, // R8
        '{8'd2,  32'h1000_0000, 2'd2, 1'b1, 1'b0, 32'hCAFE_0001, 2'b10, 4'hf, 32'hCAFE_0001, 20'h00000, 32'h0,         1'b0, 3'd1}, // R2
        '{8'd6,  32'h0000_0002, 2'd2, 1'b0, 1'b0, 32'h0,         2'b00, 4'h0, 32'h0,         20'h0,     32'h0,         1'b1, 3'd1}, // R6
        '{8'd6,  32'h1000_0001, 2'd1, 1'b1, 1'b0, 32'h0000_1234, 2'b00, 4'h0, 32'h0,         20'h0,     32'h0,         1'b1, 3'd1}, // R6
        '{8'd6,  32'h0000_0000, 2'd3, 1'b0, 1'b0, 32'h0,         2'b00, 4'h0, 32'h0,         20'h0,     32'h0,         1'b1, 3'd1}, // R6
        '{8'd11, 32'h1010_0000, 2'd2, 1'b0, 1'b0, 32'h0,         2'b00, 4'h0, 32'h0,         20'h0,     32'h0,         1'b0, 3'd1}, // R11 R2
        '{8'd3,  32'h0000_2000, 2'd2, 1'b0, 1'b0, 32'h0,         2'b00, 4'h0, 32'h0,         20'h0,     32'h0,         1'b0, 3'd1}, // R3
        '{8'd7,  32'h0000_0002, 2'd0, 1'b0, 1'b1, 32'h0,         2'b01, 4'h4, 32'h0,         20'h00002, 32'h0000_0022, 1'b0, 3'd2}  // R7 byte
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL R12 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 ready in reset", {31'b0, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 ready", {31'b0, req_ready}, 32'h1);
        chk("R13 no response", {31'b0, rsp_valid}, 32'h0);
        chk("R13 mask", irq_mask, 32'h0);
        chk("R13 status", irq_status, 32'h0);

        // R10: status read returns pre-read value, then bit 0 set
        access(32'h2000_0020, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R10 status read value", c_rdata, 32'h0);
        chk("R10 status after read", irq_status, 32'h1);

        // R1: UART write
        access(32'h2000_0000, 2'd2, 1'b1, 32'h1234_5678, 1'b0, 1'b0);
        chk("R1 tx strobe", {31'b0, c_uart}, 32'h1);
        chk("R1 tx byte", {24'b0, c_ubyte}, 32'h78);
        chk("R1 no ram", {30'b0, c_ext, c_sram}, 32'h0);
        chk("R1 tx pulse ends", {31'b0, uart_tx_valid}, 32'h0);
        chk("R1 free bit cleared", irq_status, 32'h0);

        // R6: faulted read leaves status alone
        access(32'h0000_0002, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R6 fault flag", {31'b0, c_fault}, 32'h1);
        chk("R6 status untouched", irq_status, 32'h0);

        // R11: unmapped read
        access(32'h3000_0000, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R11 unmapped data", c_rdata, 32'h0);
        chk("R11 unmapped latency", 32'(c_lat), 32'd1);
        chk("R11 no fault", {31'b0, c_fault}, 32'h0);
        chk("R10 free bit set", irq_status, 32'h1);

        // R5: mask write and read back
        access(32'h2000_0010, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
        chk("R5 mask stored", irq_mask, 32'hDEAD_BEEF);
        access(32'h2000_0010, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        chk("R5 mask read", c_rdata, 32'hDEAD_BEEF);

        // R11: unmapped write has no effect
        access(32'h3000_0004, 2'd2, 1'b1, 32'h5555_AAAA, 1'b0, 1'b0);
        chk("R11 no strobes", {28'b0, c_uart, c_tlb, c_ext, c_sram}, 32'h0);
        chk("R11 mask unchanged", irq_mask, 32'hDEAD_BEEF);

        // R4: MMU pending set, cleared by TLB write
        @(negedge clk); mmu_fault_set = 1'b1;
        @(negedge clk); mmu_fault_set = 1'b0;
        chk("R4 pending set", {31'b0, irq_status[1]}, 32'h1);
        access(32'h2000_010C, 2'd2, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b0);
        chk("R4 tlb strobe", {31'b0, c_tlb}, 32'h1);
        chk("R4 tlb index", {29'b0, c_tidx}, 32'd3);
        chk("R4 tlb data", c_tdata, 32'hCAFE_F00D);
        chk("R4 pending cleared", {31'b0, irq_status[1]}, 32'h0);
        access(32'h2000_011C, 2'd2, 1'b1, 32'h0000_0777, 1'b0, 1'b1);
        chk("R4 last index", {29'b0, c_tidx}, 32'd7);
        chk("R4 set beats clear", {31'b0, irq_status[1]}, 32'h1);
        access(32'h2000_0120, 2'd2, 1'b1, 32'h0, 1'b0, 1'b0);
        chk("R4 past window", {31'b0, c_tlb}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = $sformatf("R%0d vec%0d", v.tag, i);
            access(v.addr, v.size, v.wr, v.wdata, v.big, 1'b0);
            chk({t, " select"}, {30'b0, c_ext, c_sram}, {30'b0, v.sel});
            if (v.sel != 2'b00) chk({t, " mem_addr"}, {12'b0, c_maddr}, {12'b0, v.maddr});
            chk({t, " mem_we"}, {31'b0, c_we}, {31'b0, (v.wr && v.sel != 2'b00)});
            if (v.wr) chk({t, " be"}, {28'b0, c_be}, {28'b0, v.be});
            if (v.wr && v.sel != 2'b00) chk({t, " wdata lanes"}, c_wd, v.wd);
            if (!v.wr) chk({t, " rdata"}, c_rdata, v.rdata);
            chk({t, " fault"}, {31'b0, c_fault}, {31'b0, v.fault});
            chk({t, " R12 latency"}, 32'(c_lat), {29'b0, v.lat});
            chk({t, " R12 busy"}, {31'b0, c_busy}, 32'h0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule